// File: doc/BRIEF.md
# Reference Tracking Mode Controller

This block is the control state machine of a timing loop that follows one of several reference clocks. It decides each cycle whether the loop tracks its chosen reference (Normal), holds its last frequency (Holdover), runs on the local oscillator alone (Freerun), or sits in a correction state. In the correction state, an external phase corrector measures the offset between the loop output and the reference, so that the output phase does not move when tracking resumes. The phase detector, loop filter, oscillator and quality monitors are outside the block. It sees only one fail flag per reference and a done pulse from the corrector.

A two-bit mode select can force Holdover or Freerun. With automatic operation selected, the controller does three things. It drops into Holdover when the tracked reference fails. It comes back out once that reference is good again, either realigning at once or passing through correction, as chosen by a recovery select input. It also sends every change of reference made while locked through correction, so that the switch is hitless. The reference the loop tracks is held in a register: it follows the select input outside locked operation and changes during locked operation only at the entry into correction.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rstN` is low at a clock edge, the controller enters Freerun (`mode` = 2), with `holdover` = 0, `measEn` = 0 and `activeRef` = 0. Mode codes are Normal = 0, Holdover = 1, Freerun = 2, Correct = 3.
- R2: With `modeSel` = 2 or 3, `mode` is Freerun after the next edge, whatever the fail flags show.
- R3: With `modeSel` = 1, `mode` is Holdover after the next edge and stays there, whatever the fail flags show.
- R4: With `modeSel` = 0, in Normal, a set fail flag (bit `activeRef` of `refFail`) moves the controller to Holdover at the next edge.
- R5: With `modeSel` = 0 and `holdRecSel` = 0, in Holdover or Freerun, a clear fail flag for the selected reference moves the controller straight to Normal at the next edge.
- R6: With `modeSel` = 0 and `holdRecSel` = 1, the same recovery enters Correct (`mode` = 3). Correct persists until `measDone` is high at an edge, and the controller then enters Normal.
- R7: In Normal with automatic mode, if `refSel` differs from `activeRef` and the active reference is good, the controller enters Correct and `activeRef` takes the new value at the same edge.
- R8: In Normal, a fail flag on a reference other than `activeRef` has no effect: the mode stays Normal.
- R9: `holdover` is high exactly when `mode` is Holdover.
- R10: `measEn` is high exactly when `mode` is Correct.
- R11: While the controller stays in Normal, `activeRef` does not change.
- R12: In Correct with automatic mode, a fail flag on the active reference moves the controller to Holdover at the next edge, before `measDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeSel | input | 2 | 0 automatic, 1 forced Holdover, 2 or 3 Freerun |
| refSel | input | SelW | Requested reference index |
| holdRecSel | input | 1 | Recovery path: 0 realign directly, 1 go through Correct |
| refFail | input | NumRefs | One fail flag per reference |
| measDone | input | 1 | Corrector reports that its measurement is complete |
| mode | output | 2 | Current mode code |
| holdover | output | 1 | High in Holdover |
| measEn | output | 1 | Tells the corrector to measure |
| activeRef | output | SelW | Reference routed to the loop |

## Verification
The bench builds the block with its defaults, two references and a one-bit select. This is enough to drive every mode transition, to flag the reference that is not in use (R8), and to switch references while locked in both directions. The directed sequences visit every mode code. They hold Correct for several cycles before `measDone` arrives, and they fail a reference in the middle of a correction.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  typedef enum logic [1:0] {
    ModeNormal  = 2'd0,
    ModeHold    = 2'd1,
    ModeFree    = 2'd2,
    ModeCorrect = 2'd3
  } modeT;

  // control -> datapath
  typedef struct packed {
    logic loadRef;
  } ctrlStrobeT;

  // datapath -> control
  typedef struct packed {
    logic failActive;
    logic failReq;
    logic refDiffers;
  } refStatusT;
endpackage

// File: rtl/sync_ref_path.sv
module sync_ref_path #(
  parameter int NumRefs = 2,
  localparam int SelW = (NumRefs > 1) ? $clog2(NumRefs) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SelW-1:0]               refSel,
  input  logic [NumRefs-1:0]            refFail,
  input  sync_mode_pkg::ctrlStrobeT     strobe,
  output logic [SelW-1:0]               activeRef,
  output sync_mode_pkg::refStatusT      status
);
  logic [NumRefs-1:0] hitActive, hitReq;

  always_ff @(posedge clk) begin
    if (!rstN)              activeRef <= '0;
    else if (strobe.loadRef) activeRef <= refSel;
  end

  for (genvar i = 0; i < NumRefs; i++) begin : gLookup
    assign hitActive[i] = refFail[i] && (activeRef == SelW'(i));
    assign hitReq[i]    = refFail[i] && (refSel == SelW'(i));
  end

  always_comb begin
    status.failActive = |hitActive;
    status.failReq    = |hitReq;
    status.refDiffers = (refSel != activeRef);
  end
endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                modeSel,
  input  logic                      holdRecSel,
  input  logic                      measDone,
  input  sync_mode_pkg::refStatusT  status,
  output logic [1:0]                mode,
  output logic                      holdover,
  output logic                      measEn,
  output sync_mode_pkg::ctrlStrobeT strobe
);
  import sync_mode_pkg::*;

  modeT state, nxt;

  always_comb begin
    nxt = state;
    if (modeSel[1]) begin
      nxt = ModeFree;
    end else if (modeSel[0]) begin
      nxt = ModeHold;
    end else begin
      unique case (state)
        ModeNormal: begin
          if (status.failActive)      nxt = ModeHold;
          else if (status.refDiffers) nxt = ModeCorrect;
        end
        ModeCorrect: begin
          if (status.failActive) nxt = ModeHold;
          else if (measDone)     nxt = ModeNormal;
        end
        default: begin
          if (status.failReq)  nxt = ModeHold;
          else if (holdRecSel) nxt = ModeCorrect;
          else                 nxt = ModeNormal;
        end
      endcase
    end
  end

  // outside locked operation the tracked reference follows the request;
  // while locked it moves only on the way into correction
  always_comb begin
    strobe.loadRef = ((state == ModeHold) || (state == ModeFree)) ||
                     ((state == ModeNormal) && (nxt == ModeCorrect));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ModeFree;
      holdover <= 1'b0;
      measEn   <= 1'b0;
    end else begin
      state    <= nxt;
      holdover <= (nxt == ModeHold);
      measEn   <= (nxt == ModeCorrect);
    end
  end

  assign mode = state;
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl #(
  parameter int NumRefs = 2,
  localparam int SelW = (NumRefs > 1) ? $clog2(NumRefs) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [SelW-1:0]    refSel,
  input  logic               holdRecSel,
  input  logic [NumRefs-1:0] refFail,
  input  logic               measDone,
  output logic [1:0]         mode,
  output logic               holdover,
  output logic               measEn,
  output logic [SelW-1:0]    activeRef
);
  sync_mode_pkg::ctrlStrobeT strobe;
  sync_mode_pkg::refStatusT  status;

  sync_mode_fsm uFsm (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .holdRecSel(holdRecSel),
    .measDone(measDone), .status(status), .mode(mode),
    .holdover(holdover), .measEn(measEn), .strobe(strobe)
  );

  sync_ref_path #(.NumRefs(NumRefs)) uPath (
    .clk(clk), .rstN(rstN), .refSel(refSel), .refFail(refFail),
    .strobe(strobe), .activeRef(activeRef), .status(status)
  );
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk #(
  parameter int NumRefs = 2,
  localparam int SelW = (NumRefs > 1) ? $clog2(NumRefs) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         modeSel,
  input logic [SelW-1:0]    refSel,
  input logic               holdRecSel,
  input logic [NumRefs-1:0] refFail,
  input logic               measDone,
  input logic [1:0]         mode,
  input logic               holdover,
  input logic               measEn,
  input logic [SelW-1:0]    activeRef
);
  a_r1_reset_free: assert property (@(posedge clk)
    !rstN |=> (mode == 2'd2) && !holdover && !measEn && (activeRef == '0));

  a_r2_forced_free: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> (mode == 2'd2));

  a_r3_forced_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1) |=> (mode == 2'd1));

  a_r4_fail_to_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0) && (mode == 2'd0) && refFail[activeRef] |=> (mode == 2'd1));

  a_r6_wait_done: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0) && (mode == 2'd3) && !refFail[activeRef] && !measDone
    |=> (mode == 2'd3));

  a_r9_holdover_flag: assert property (@(posedge clk) disable iff (!rstN)
    holdover == (mode == 2'd1));

  a_r10_meas_flag: assert property (@(posedge clk) disable iff (!rstN)
    measEn == (mode == 2'd3));

  a_r11_ref_steady: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> (mode == 2'd0) -> $stable(activeRef));
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk #(.NumRefs(NumRefs)) uChk (.*);

// File: tb/sync_mode_ctrl_test.sv
module sync_mode_ctrl_test;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic [0:0] refSel;
  logic       holdRecSel;
  logic [1:0] refFail;
  logic       measDone;
  logic [1:0] mode;
  logic       holdover;
  logic       measEn;
  logic [0:0] activeRef;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  sync_mode_ctrl uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refSel(refSel),
    .holdRecSel(holdRecSel), .refFail(refFail), .measDone(measDone),
    .mode(mode), .holdover(holdover), .measEn(measEn), .activeRef(activeRef)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock edge, then sample 1 time unit later
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chkMode(input string req, input int expMode, input int expRef);
    chk(req, mode, expMode);
    chk(req, holdover, expMode == 1);
    chk(req, measEn, expMode == 3);
    chk(req, activeRef, expRef);
  endtask

  task automatic tReset();
    rstN = 0; modeSel = 0; refSel = 0; holdRecSel = 0; refFail = 0; measDone = 0;
    step(); step();
    chkMode("R1", 2, 0);
    rstN = 1;
  endtask

  task automatic tDirectLock();   // Freerun -> Normal directly
    step();
    chkMode("R5", 0, 0);
  endtask

  task automatic tOtherFail();
    refFail = 2'b10;
    step(); step();
    chkMode("R8", 0, 0);
    refFail = 2'b01;
    step();
    chkMode("R4", 1, 0);
    step();
    chkMode("R4", 1, 0);
  endtask

  task automatic tDirectRecover();
    holdRecSel = 0; refFail = 0;
    step();
    chkMode("R5", 0, 0);
  endtask

  task automatic tPhaseKeep();
    refFail = 2'b01;
    step();
    chkMode("R4", 1, 0);
    holdRecSel = 1; refFail = 0;
    step();
    chkMode("R6", 3, 0);
    step(); step();
    chkMode("R6", 3, 0);
    measDone = 1;
    step();
    measDone = 0;
    chkMode("R6", 0, 0);
  endtask

  task automatic tSwitch();
    refSel = 1;
    step();
    chkMode("R7", 3, 1);
    step();
    chkMode("R7", 3, 1);
    measDone = 1;
    step();
    measDone = 0;
    chkMode("R7", 0, 1);
    step();
    chkMode("R11", 0, 1);
  endtask

  task automatic tFailInCorrect();
    refSel = 0;
    step();
    chkMode("R7", 3, 0);
    refFail = 2'b01;
    step();
    chkMode("R12", 1, 0);
    refFail = 0; holdRecSel = 0;
    step();
    chkMode("R5", 0, 0);
  endtask

  task automatic tForced();
    modeSel = 1;
    step(); step(); step();
    chkMode("R3", 1, 0);
    modeSel = 2; refFail = 2'b11;
    step();
    chkMode("R2", 2, 0);
    modeSel = 3; refFail = 0;
    step();
    chkMode("R2", 2, 0);
    modeSel = 0; refSel = 1; holdRecSel = 0;
    step();
    chkMode("R5", 0, 1);
  endtask

  initial begin
    tReset();
    tDirectLock();
    tOtherFail();
    tDirectRecover();
    tPhaseKeep();
    tSwitch();
    tFailInCorrect();
    tForced();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(ClkPeriod * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule